// File: doc/BRIEF.md
# Configurable product-term AND plane

This block is the AND plane of one programmable logic block. It takes 26 routed input signals and forms 68 product terms from them. Each term may use any input directly, inverted, or not at all, as its configuration bits select. Terms 0 to 63 are general logic terms for a later OR stage. The last four terms have fixed control roles for the logic block: two output-enable terms, one block-wide asynchronous clear term and one block-wide asynchronous set term. Every flip-flop in the logic block is cleared or set together by these shared terms.

The configuration is held in one long shift chain. It is loaded one bit per clock while `cfg_en` is high and is then held static. All product-term outputs are registered, with one clock of latency. They are forced low during a load and after reset. Reset fills the chain with ones, so every term then has both polarities of every input and stays at 0 until a real configuration is loaded. The control terms therefore stay inactive.

Top module: `pterm_array`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives every term output to 0 on that edge and sets every configuration bit to 1. While `cfg_en` stays low after reset, every term output therefore remains 0.
- R2: Every term output is 0 in the cycle after any clock edge at which `cfg_en` is high.
- R3: At each clock edge with `cfg_en` high and `rst` low, the chain shifts by one place toward higher indices and `cfg_din` enters at bit 0. After N_TERMS*2*N_IN such shifts, the bit sent first sits at the highest index. Term t owns bits [t*2*N_IN +: 2*N_IN]. Within a term, bit 2i enables the true literal of `in_sig[i]` and bit 2i+1 enables the complemented literal.
- R4: A term with no enabled literal outputs 1.
- R5: A term with both literals of the same input enabled outputs 0 for every input value.
- R6: A term otherwise outputs the AND of its enabled literals: `in_sig[i]` for a true literal and `~in_sig[i]` for a complemented one.
- R7: Terms 0..63 appear on `logic_pt[t]`. Term 64 drives `oe_pt[0]`, term 65 drives `oe_pt[1]`, term 66 drives `arst_pt` and term 67 drives `aset_pt`.
- R8: With `cfg_en` low, the outputs after a clock edge reflect `in_sig` as sampled at that edge. The latency is one cycle.
- R9: While `cfg_en` is low, `cfg_din` has no effect and the configuration is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration bit |
| in_sig | input | 26 | Routed input signals |
| logic_pt | output | 64 | General logic product terms |
| oe_pt | output | 2 | Output-enable product terms |
| arst_pt | output | 1 | Block-wide asynchronous clear term |
| aset_pt | output | 1 | Block-wide asynchronous set term |

## Verification
A wrong chain bit is invisible until its term is evaluated with `cfg_en` low. It then shows on the output of that one term in the cycle after the first input pattern that the stray literal decides. A misordered shift corrupts many terms at once, and that shows on the first cycle after loading. The bench therefore loads a varied image, including empty terms and contradictory terms, and compares all 68 outputs on every clock against a behavioural model.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
  localparam int DEF_N_IN    = 26;
  localparam int DEF_N_LOGIC = 64;
  localparam int DEF_N_OE    = 2;
  // control term offsets after the logic terms (order is fixed behaviour)
  localparam int CTRL_ARST_OFS = 0;  // relative to first term after OE terms
  localparam int CTRL_ASET_OFS = 1;
  localparam int N_RST_SET     = 2;
endpackage

// File: rtl/pterm_cfg_chain.sv
module pterm_cfg_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst)
      bits <= '1;
    else if (shift_en)
      bits <= {bits[LEN-2:0], din};
  end
endmodule

// File: rtl/pterm_lit_buf.sv
module pterm_lit_buf #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0]   x,
  output logic [2*N_IN-1:0] lits
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = x[i];
    assign lits[2*i+1] = ~x[i];
  end
endmodule

// File: rtl/pterm_and.sv
module pterm_and #(
  parameter int W = 8
) (
  input  logic [W-1:0] lits,
  input  logic [W-1:0] mask,
  output logic         term
);
  assign term = &(lits | ~mask);
endmodule

// File: rtl/pterm_array.sv
module pterm_array
  import pterm_pkg::*;
#(
  parameter int N_IN    = DEF_N_IN,
  parameter int N_LOGIC = DEF_N_LOGIC,
  parameter int N_OE    = DEF_N_OE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               cfg_din,
  input  logic [N_IN-1:0]    in_sig,
  output logic [N_LOGIC-1:0] logic_pt,
  output logic [N_OE-1:0]    oe_pt,
  output logic               arst_pt,
  output logic               aset_pt
);
  localparam int TW      = 2 * N_IN;
  localparam int N_TERMS = N_LOGIC + N_OE + N_RST_SET;
  localparam int CFG_LEN = N_TERMS * TW;

  logic [CFG_LEN-1:0] cfg_bits;
  logic [TW-1:0]      lits;
  logic [N_TERMS-1:0] pt_d;
  logic [N_TERMS-1:0] pt_q;

  pterm_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .din(cfg_din), .bits(cfg_bits)
  );

  pterm_lit_buf #(.N_IN(N_IN)) u_lits (.x(in_sig), .lits(lits));

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    pterm_and #(.W(TW)) u_and (
      .lits(lits), .mask(cfg_bits[t*TW +: TW]), .term(pt_d[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_en)
      pt_q <= '0;
    else
      pt_q <= pt_d;
  end

  assign logic_pt = pt_q[N_LOGIC-1:0];
  assign oe_pt    = pt_q[N_LOGIC +: N_OE];
  assign arst_pt  = pt_q[N_LOGIC + N_OE + CTRL_ARST_OFS];
  assign aset_pt  = pt_q[N_LOGIC + N_OE + CTRL_ASET_OFS];
endmodule

// File: rtl/pterm_array_chk.sv
module pterm_array_chk #(
  parameter int CFG_LEN = 8,
  parameter int N_TERMS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic               cfg_din,
  input logic [CFG_LEN-1:0] chain,
  input logic [N_TERMS-1:0] terms
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (terms == '0));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !cfg_en) |=> (terms == '0));

  p_load_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (terms == '0));

  p_shift_entry_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (chain[0] == $past(cfg_din)));

  p_shift_move_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (chain[CFG_LEN-1:1] == $past(chain[CFG_LEN-2:0])));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(chain));
endmodule

bind pterm_array pterm_array_chk #(
  .CFG_LEN(CFG_LEN), .N_TERMS(N_TERMS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
  .chain(cfg_bits), .terms(pt_q)
);

// File: tb/tb_pterm_array.sv
`timescale 1ns/1ps
module tb_pterm_array;
  localparam int N_IN = 26, N_LOGIC = 64, N_OE = 2;
  localparam int TW = 2 * N_IN;
  localparam int N_TERMS = N_LOGIC + N_OE + 2;
  localparam int CFG_LEN = N_TERMS * TW;

  logic clk = 0, rst = 1, cfg_en = 0, cfg_din = 0;
  logic [N_IN-1:0] in_sig = '0;
  logic [N_LOGIC-1:0] logic_pt;
  logic [N_OE-1:0] oe_pt;
  logic arst_pt, aset_pt;

  pterm_array dut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_sig(in_sig), .logic_pt(logic_pt), .oe_pt(oe_pt),
    .arst_pt(arst_pt), .aset_pt(aset_pt));

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";
  logic [CFG_LEN-1:0] m_cfg;
  logic [CFG_LEN-1:0] img;
  logic [N_TERMS-1:0] exp_q = '0;
  logic checking = 0;

  function automatic logic eval_term(input logic [CFG_LEN-1:0] c, input int t,
                                     input logic [N_IN-1:0] x);
    logic v = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (c[t*TW + 2*i] && !x[i]) v = 1'b0;
      if (c[t*TW + 2*i + 1] && x[i]) v = 1'b0;
    end
    return v;
  endfunction

  // behavioural reference: outputs registered, configuration shifts
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      exp_q = '0;
      m_cfg = '1;
    end else if (cfg_en) begin
      exp_q = '0;
      m_cfg = {m_cfg[CFG_LEN-2:0], cfg_din};
    end else begin
      for (int t = 0; t < N_TERMS; t++) exp_q[t] = eval_term(m_cfg, t, in_sig);
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [N_TERMS-1:0] got;
      got = {aset_pt, arst_pt, oe_pt, logic_pt};
      vectors++;
      if (got !== exp_q) begin
        errors++;
        $display("FAIL %s: got %h expected %h", tag, got, exp_q);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input logic [N_IN-1:0] x);
    in_sig = x;
    @(negedge clk);
  endtask

  task automatic set_lit(input int t, input int i, input int comp);
    img[t*TW + 2*i + comp] = 1'b1;
  endtask

  task automatic load_image();
    cfg_en = 1;
    for (int k = CFG_LEN - 1; k >= 0; k--) begin
      cfg_din = img[k];
      in_sig = N_IN'($urandom);
      @(negedge clk);
    end
    cfg_en = 0;
    cfg_din = 0;
  endtask

  initial begin
    // R1: reset state
    @(negedge clk); checking = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1 after reset";
    for (int k = 0; k < 20; k++) step(N_IN'($urandom));

    // build configuration image (R3 field positions, R4/R5/R6/R7 roles)
    img = '0;
    for (int t = 0; t < N_LOGIC; t++) begin
      case (t % 4)
        0: ;                                        // R4 empty term
        1: begin set_lit(t, t % N_IN, 0); set_lit(t, t % N_IN, 1); end // R5
        2: begin set_lit(t, t % N_IN, 0); set_lit(t, (t + 5) % N_IN, 1); end
        default: img[t*TW +: TW] = TW'({$urandom, $urandom} & {$urandom, $urandom}
                                       & {$urandom, $urandom} & {$urandom, $urandom});
      endcase
    end
    set_lit(64, 0, 0);                 // R7 oe_pt[0] = in0
    set_lit(65, 1, 1);                 // R7 oe_pt[1] = ~in1
    set_lit(66, 2, 0); set_lit(66, 3, 0); // R7 arst_pt = in2 & in3
                                       // R7 aset_pt empty -> 1

    tag = "R2 during load";
    load_image();

    tag = "R3 R4 R5 R6 R7 R8 patterns";
    step('0);
    step('1);
    for (int i = 0; i < N_IN; i++) step(N_IN'(1) << i);
    for (int i = 0; i < N_IN; i++) step(~(N_IN'(1) << i));
    for (int k = 0; k < 400; k++) step(N_IN'($urandom));

    tag = "R9 din ignored";
    for (int k = 0; k < 300; k++) begin
      cfg_din = $urandom;
      step(N_IN'($urandom));
    end
    cfg_din = 0;

    tag = "R1 mid-run reset";
    rst = 1;
    repeat (2) step(N_IN'($urandom));
    rst = 0;
    for (int k = 0; k < 20; k++) step(N_IN'($urandom));

    tag = "R2 R3 reload";
    load_image();
    tag = "R6 R8 after reload";
    for (int k = 0; k < 100; k++) step(N_IN'($urandom));

    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule